// File: doc/BRIEF.md
# IO Rail Deep Power-Down Controller

This block manages the deep power-down state of up to sixty IO rails. The rails are split into two banks of thirty. Each bank has a command register and a read-only state register. Software writes a command word to a bank. The word holds a two-bit operation code and a thirty-bit rail selection. A small per-bank sequencer then waits a programmable settle interval and moves every selected rail to the commanded state. Each rail's state drives one bit of the `rail_dpd` output.

Two shared registers gate and time the sequencers. A sampling-enable bit must be 1 for any bank to make progress. A settle register holds the wait, counted in bus clock cycles; software sizes it so the interval covers at least 200 ns. Register access is a plain single-cycle write strobe with a combinational read of the addressed word.

Each bank sequencer has four states:
- IDLE: nothing pending.
- HOLD: a command is pending but sampling is off.
- SETTLE: the settle counter is running.
- APPLY: the rail states are updated, and the sequencer goes back to IDLE.

The named transitions are:
- *accept*: a command write with an active code moves the sequencer to SETTLE, or to HOLD when sampling is off.
- *cancel*: a command write with an inactive code moves it to IDLE from any state.
- *resume*: HOLD moves to SETTLE once sampling is on.
- *pause*: SETTLE moves to HOLD when sampling goes off.
- *expire*: SETTLE moves to APPLY when the count reaches zero.
- *finish*: APPLY moves to IDLE.

Top module: `dpd_rail_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all of `rail_dpd` is 0, both state registers read 0, the sampling register reads 0 and the settle register reads 10.
- R2: The register map uses these byte addresses:
  - 0x020: sampling enable, bit 0.
  - 0x1B8 and 0x1C0: bank 0 and bank 1 command words.
  - 0x1BC and 0x1C4: bank 0 and bank 1 state words, with bits 31:30 reading 0.
  - 0x1C8: settle count, 10 bits wide, with upper bits reading 0.
  
  Any other address reads 0.
- R3: Command code 2 (bits 31:30) puts every rail selected in bits 29:0 into deep power-down. State bit i of bank b becomes 1, and so does `rail_dpd[30*b+i]`.
- R4: Command code 1 returns every selected rail to powered, so its state bit and output become 0.
- R5: With settle value T and sampling on, a command captured at clock edge E changes the rails at edge E+T+2. Nothing changes at edge E+T+1 or earlier. T=0 is valid.
- R6: Codes 0 and 3 change no rail. Such a write also cancels a command still pending on that bank.
- R7: While sampling is 0, a bank makes no progress. If sampling is enabled at edge S, a pending command applies at S+T+3. A command that was paused mid-count restarts its full count on resume.
- R8: A new command written to a bank before its previous command applied replaces that command. The count restarts from the new write.
- R9: Unselected rails keep their state. A selected rail that is already in the commanded state stays there.
- R10: After a command applies, its word reads back with bits 31:30 equal to 0 and the selection bits unchanged.
- R11: The two banks sequence independently, so overlapping commands on both banks each complete on their own schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 12 | Byte address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rail_dpd | output | 60 | Per-rail deep power-down outputs, bank-major |

## Verification
Commands are tried with the following patterns, each targeting a distinct failure:
- Sparse masks on each bank separate a wrong bit mapping from a wrong bank routing.
- Masks that include rails already in the target state separate a set/clear update from a toggle.
- Settle values 0, 3 and 6 pin the exact completion edge, with checks one edge early and on time.
- Sampling-off, mid-count pause, back-to-back rewrite and inactive-code runs distinguish freezing from restarting, replacing from merging, and cancelling from ignoring.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    parameter int BANK_RAILS = 30;
    parameter int CODE_LSB   = 30;

    parameter int OFS_SAMPLE   = 'h020;
    parameter int OFS_REQ_BASE = 'h1B8;
    parameter int OFS_STAT_GAP = 4;
    parameter int OFS_STRIDE   = 8;
    parameter int OFS_SETTLE   = 'h1C8;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_LEAVE = 2'd1,
        CMD_ENTER = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SETTLE,
        ST_APPLY
    } seq_state_t;

endpackage

// File: rtl/dpd_settle_timer.sv
module dpd_settle_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/dpd_bank.sv
module dpd_bank
    import dpd_pkg::*;
#(
    parameter int TIM_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_req,
    input  logic [31:0]           wr_data,
    input  logic                  sample_en,
    input  logic [TIM_W-1:0]      settle_val,
    output logic [31:0]           req_word,
    output logic [BANK_RAILS-1:0] status
);
    seq_state_t            state_q, state_d;
    logic [31:0]           req_q;
    logic [BANK_RAILS-1:0] status_q;
    logic                  load, dec, apply, done;
    cmd_t                  new_code, cur_code;
    logic                  new_active;
    logic [BANK_RAILS-1:0] sel_mask;

    assign new_code   = cmd_t'(wr_data[CODE_LSB +: 2]);
    assign cur_code   = cmd_t'(req_q[CODE_LSB +: 2]);
    assign new_active = (new_code == CMD_ENTER) || (new_code == CMD_LEAVE);
    assign sel_mask   = req_q[BANK_RAILS-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (wr_req) begin
            if (new_active) state_d = sample_en ? ST_SETTLE : ST_HOLD; // accept
            else            state_d = ST_IDLE;                         // cancel
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_HOLD:   if (sample_en) state_d = ST_SETTLE;         // resume
                ST_SETTLE: begin
                    if (!sample_en) state_d = ST_HOLD;                 // pause
                    else if (done)  state_d = ST_APPLY;                // expire
                end
                ST_APPLY:  state_d = ST_IDLE;                          // finish
            endcase
        end
    end

    // sequencer outputs
    always_comb begin
        load  = (state_d == ST_SETTLE) && (wr_req || (state_q == ST_HOLD));
        dec   = !wr_req && (state_q == ST_SETTLE) && sample_en && !done;
        apply = !wr_req && (state_q == ST_APPLY);
    end

    dpd_settle_timer #(.W(TIM_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (settle_val),
        .dec      (dec),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= '0;
            status_q <= '0;
        end else if (wr_req) begin
            req_q <= wr_data;
        end else if (apply) begin
            req_q[CODE_LSB +: 2] <= CMD_IDLE;
            if (cur_code == CMD_ENTER)      status_q <= status_q | sel_mask;
            else if (cur_code == CMD_LEAVE) status_q <= status_q & ~sel_mask;
        end
    end

    assign req_word = req_q;
    assign status   = status_q;

    assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_APPLY) |=> $stable(status_q));

    assert_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY && !wr_req && cur_code == CMD_ENTER)
        |=> ((status_q & req_q[BANK_RAILS-1:0]) == req_q[BANK_RAILS-1:0]));

    assert_leave_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY && !wr_req && cur_code == CMD_LEAVE)
        |=> ((status_q & req_q[BANK_RAILS-1:0]) == '0));

    assert_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !sample_en && !wr_req) |=> (state_q == ST_HOLD));

    assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !new_active) |=> (state_q == ST_IDLE && $stable(status_q)));

    assert_code_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY && !wr_req) |=> (req_q[CODE_LSB +: 2] == CMD_IDLE));
endmodule

// File: rtl/dpd_rail_ctrl.sv
module dpd_rail_ctrl
    import dpd_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int TIM_W     = 10,
    parameter int TIM_RST   = 10,
    parameter int ADDR_W    = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    output logic [NUM_BANKS*BANK_RAILS-1:0] rail_dpd
);
    localparam logic [ADDR_W-1:0] A_SAMPLE = ADDR_W'(OFS_SAMPLE);
    localparam logic [ADDR_W-1:0] A_SETTLE = ADDR_W'(OFS_SETTLE);

    logic             sample_q;
    logic [TIM_W-1:0] settle_q;
    logic [31:0]           req_word [NUM_BANKS];
    logic [BANK_RAILS-1:0] stat     [NUM_BANKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= 1'b0;
            settle_q <= TIM_W'(TIM_RST);
        end else if (bus_wr) begin
            if (bus_addr == A_SAMPLE) sample_q <= bus_wdata[0];
            if (bus_addr == A_SETTLE) settle_q <= bus_wdata[TIM_W-1:0];
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(OFS_REQ_BASE + b*OFS_STRIDE);
        logic hit;
        assign hit = bus_wr && (bus_addr == A_REQ);

        dpd_bank #(.TIM_W(TIM_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_req     (hit),
            .wr_data    (bus_wdata),
            .sample_en  (sample_q),
            .settle_val (settle_q),
            .req_word   (req_word[b]),
            .status     (stat[b])
        );

        assign rail_dpd[b*BANK_RAILS +: BANK_RAILS] = stat[b];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_SAMPLE) bus_rdata[0] = sample_q;
        if (bus_addr == A_SETTLE) bus_rdata[TIM_W-1:0] = settle_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(OFS_REQ_BASE + b*OFS_STRIDE))
                bus_rdata = req_word[b];
            if (bus_addr == ADDR_W'(OFS_REQ_BASE + b*OFS_STRIDE + OFS_STAT_GAP))
                bus_rdata[BANK_RAILS-1:0] = stat[b];
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (rail_dpd == '0 && sample_q == 1'b0));
endmodule

// File: tb/sim_dpd_rail_ctrl.sv
module sim_dpd_rail_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [59:0] rail_dpd;

    always #10 clk = ~clk; // 50 MHz

    dpd_rail_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rail_dpd(rail_dpd)
    );

    typedef struct {
        int          due;
        logic [59:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t    sb[$];
    int          edge_cnt = 0;
    int          checks = 0;
    int          fails = 0;
    logic [59:0] model = '0;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare as the design produces results
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            if (sb[0].due == edge_cnt) begin
                chk(rail_dpd == sb[0].exp, sb[0].tag, 64'(rail_dpd), 64'(sb[0].exp));
                void'(sb.pop_front());
            end else if (sb[0].due < edge_cnt) begin
                chk(1'b0, {sb[0].tag, " missed"}, 64'(edge_cnt), 64'(sb[0].due));
                void'(sb.pop_front());
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, output int e);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 e = edge_cnt;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1 chk(bus_rdata == exp, tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic push(input int due, input logic [59:0] v, input string tag);
        sb_item_t it;
        it.due = due; it.exp = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_cmd(input int e, input int b, input logic [1:0] c,
                              input logic [29:0] m, input int t, input string tag);
        logic [59:0] sel;
        push(e + t + 1, model, {tag, " early"});
        sel = 60'(m) << (30 * b);
        if (c == 2'd2) model = model | sel;
        else if (c == 2'd1) model = model & ~sel;
        push(e + t + 2, model, tag);
    endtask

    task automatic cmd(input int b, input logic [1:0] c, input logic [29:0] m,
                       input int t, input string tag);
        int e;
        wr(12'h1B8 + 12'(8 * b), {c, m}, e);
        expect_cmd(e, b, c, m, t, tag);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int e, ea, eb, es;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1 chk(rail_dpd == '0, "R1 outputs", 64'(rail_dpd), 64'd0);
        rd(12'h020, 32'd0, "R1 sample");
        rd(12'h1C8, 32'd10, "R1 settle");
        rd(12'h1BC, 32'd0, "R1 state0");
        rd(12'h1C4, 32'd0, "R1 state1");

        // R2 register map
        wr(12'h1C8, 32'hFFFF_FFFF, e);
        rd(12'h1C8, 32'h3FF, "R2 settle width");
        rd(12'h100, 32'd0, "R2 unmapped");
        wr(12'h1C8, 32'd3, e);
        rd(12'h1C8, 32'd3, "R2 settle");
        wr(12'h020, 32'd1, e);
        rd(12'h020, 32'd1, "R2 sample");

        // R3 enter on each bank
        cmd(0, 2'd2, 30'h5, 3, "R3 bank0 enter");
        drain();
        cmd(1, 2'd2, 30'h2000_0000, 3, "R3 bank1 enter");
        drain();
        rd(12'h1C4, 32'h2000_0000, "R3 state1");
        rd(12'h1C0, 32'h2000_0000, "R10 code cleared");

        // R4 leave, R9 already-in-state rails
        cmd(0, 2'd1, 30'h11, 3, "R4 R9 leave");
        drain();
        cmd(0, 2'd2, 30'h4, 3, "R9 re-enter");
        drain();
        rd(12'h1BC, 32'h4, "R9 state0");

        // R6 inactive codes and cancel
        cmd(0, 2'd0, 30'h3FFF_FFFF, 3, "R6 code0");
        drain();
        cmd(1, 2'd3, 30'h3FFF_FFFF, 3, "R6 code3");
        drain();
        wr(12'h1B8, {2'd2, 30'h100}, ea);
        wr(12'h1B8, {2'd0, 30'h100}, eb);
        push(ea + 5, model, "R6 cancel");
        push(ea + 12, model, "R6 cancel late");
        drain();

        // R7 sampling off: hold, then resume
        wr(12'h020, 32'd0, e);
        wr(12'h1B8, {2'd2, 30'h8}, e);
        push(e + 20, model, "R7 held");
        drain();
        wr(12'h020, 32'd1, es);
        expect_cmd(es + 1, 0, 2'd2, 30'h8, 3, "R7 resume");
        drain();

        // R7 pause mid-count restarts full count
        wr(12'h1C8, 32'd6, e);
        wr(12'h1C0, {2'd2, 30'h1}, e);
        wr(12'h020, 32'd0, es);
        push(e + 8, model, "R7 paused");
        drain();
        repeat (4) @(negedge clk);
        wr(12'h020, 32'd1, es);
        expect_cmd(es + 1, 1, 2'd2, 30'h1, 6, "R7 restart");
        drain();

        // R8 rewrite replaces pending command
        wr(12'h1B8, {2'd2, 30'h40}, ea);
        push(ea + 8, model, "R8 first dropped");
        wr(12'h1B8, {2'd2, 30'h80}, eb);
        expect_cmd(eb, 0, 2'd2, 30'h80, 6, "R8 replace");
        drain();

        // R11 overlapping banks
        wr(12'h1C8, 32'd3, e);
        cmd(0, 2'd1, 30'h4, 3, "R11 bank0");
        cmd(1, 2'd1, 30'h1, 3, "R11 bank1");
        drain();

        // R5 zero settle
        wr(12'h1C8, 32'd0, e);
        cmd(0, 2'd2, 30'h200, 0, "R5 zero settle");
        drain();

        rd(12'h1BC, {2'b00, model[29:0]}, "R3 R4 final state0");
        rd(12'h1C4, {2'b00, model[59:30]}, "R3 R4 final state1");
        rd(12'h1B8, 32'h200, "R10 final word");

        summary();
        $finish;
    end
endmodule